// File: doc/BRIEF.md
# Bit Field Insert Execution Unit

This block decodes and executes a bit-field insert operation on 32-bit register values. It accepts one instruction word per cycle in either of two layouts. The first is a conditional 32-bit word. The second is a compact layout made of two halfwords. Both layouts decode into one shared pair of field bounds, a top bit and a bottom bit. The datapath then overwrites that span of the destination value with the low bits of the source value. When the source register field is all ones, zeros are written into the span instead, which makes the operation a field clear.

The caller supplies the source and destination register contents and the current N, Z, C and V flags. The block returns the new destination value, the destination register index, a write strobe and an undefined-instruction flag. All of these are registered and appear exactly one cycle after the input is valid, whatever the data or flags. Register file access, fetch, hazards and trap entry belong to the surrounding pipeline.

Top module: `bfx_unit`

## Requirements
- R1: For an accepted write, result bits from the top bound down to the bottom bound take the low (top−bottom+1) bits of the source value. Every other result bit equals the destination value.
- R2: With `fmt_sel_i`=0 (wide layout), the fields are at these positions: condition [31:28], top bound [20:16], destination index [15:12], bottom bound [11:7], source index [3:0]. Bits [27:21] must equal 0111110 and bits [6:4] must equal 001.
- R3: With `fmt_sel_i`=1 (compact layout), the fields are at these positions: source index [19:16], destination index [11:8], top bound [4:0]. The bottom bound is the 5-bit value {instr[14:12], instr[7:6]}. Bits [31:27]=11110, [25:24]=11, [23:21]=011, [20]=0 and [15]=0 are required.
- R4: A source index of 15 makes the operation write zeros into the field instead of source bits.
- R5: A destination index of 15 raises `undef_o` and keeps `wr_en_o` low.
- R6: A top bound below the bottom bound raises `undef_o` and keeps `wr_en_o` low.
- R7: In the wide layout, a mismatch in any fixed opcode bit, or a condition field of 1111, raises `undef_o`. In the compact layout, a mismatch in any required bit raises `undef_o`.
- R8: The wide-layout condition uses `flags_i` = {N,Z,C,V}. The codes are: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always. A failed condition gives a valid output with `wr_en_o` and `undef_o` both low.
- R9: The compact layout is unconditional: `flags_i` has no effect on its outputs.
- R10: `out_valid_o` is high in exactly the cycle after each cycle with `in_valid_i` high. `wr_en_o` and `undef_o` are low whenever `out_valid_o` is low.
- R11: When a valid output has `wr_en_o` low, `result_o` equals the destination value that was presented.
- R12: The compact-layout reserved bits [26] and [5] have no effect on any output.
- R13: After reset, `out_valid_o`, `wr_en_o`, `undef_o`, `result_o` and `dst_idx_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction and operands are valid this cycle |
| fmt_sel_i | input | 1 | 0 = wide conditional layout, 1 = compact layout |
| instr_i | input | 32 | Instruction word |
| src_val_i | input | 32 | Source register value |
| dst_val_i | input | 32 | Current destination register value |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| out_valid_o | output | 1 | Result valid, one cycle after input |
| result_o | output | 32 | New destination value |
| dst_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Destination write strobe |
| undef_o | output | 1 | Undefined-instruction flag |

## Verification
The hardest situations to reach from the ports are a valid opcode whose bounds cross, and a legal wide word whose condition fails on the supplied flags. Random field values seldom land on the interesting edges: top bound 31, bottom bound 0, equal bounds, and register index 15. The stimulus therefore assembles words from individual fields and biases those fields toward the edge values. It flips single opcode bits on a fraction of words and draws flags at random for every condition code. Directed cases add the full-width insert, single-bit fields at both ends, the clear form, and toggling of the compact reserved bits.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int IDX_W  = 4;
  localparam logic [IDX_W-1:0] IDX_SPECIAL = '1;

  typedef enum logic { FMT_WIDE = 1'b0, FMT_COMPACT = 1'b1 } fmt_e;

  typedef struct packed {
    logic [POS_W-1:0] top;
    logic [POS_W-1:0] bot;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic [3:0]       cond;
    logic             enc_bad;
  } fields_t;

  // Ones from bit bot up to bit top; no DATA_W+1 intermediate needed.
  function automatic logic [DATA_W-1:0] span_mask(input logic [POS_W-1:0] top,
                                                  input logic [POS_W-1:0] bot);
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] lo;
    hi = {DATA_W{1'b1}} >> (POS_W'(DATA_W - 1) - top);
    lo = {DATA_W{1'b1}} << bot;
    return hi & lo;
  endfunction

  // flags = {N,Z,C,V}
  function automatic logic cond_holds(input logic [3:0] cond, input logic [3:0] flags);
    logic n, z, c, v, base;
    {n, z, c, v} = flags;
    case (cond[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    return (cond[0] && cond[3:1] != 3'd7) ? ~base : base;
  endfunction
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic              fmt_i,
  input  logic [31:0]       instr_i,
  output fields_t           fields_o,
  output logic              conditional_o
);
  fields_t wide_f;
  fields_t cmp_f;
  logic    wide_bad;
  logic    cmp_bad;

  always_comb begin
    wide_bad = (instr_i[31:28] == 4'hF) ||
               (instr_i[27:21] != 7'b0111110) ||
               (instr_i[6:4] != 3'b001);
    wide_f.cond    = instr_i[31:28];
    wide_f.top     = instr_i[20:16];
    wide_f.rd      = instr_i[15:12];
    wide_f.bot     = instr_i[11:7];
    wide_f.rn      = instr_i[3:0];
    wide_f.enc_bad = wide_bad;
  end

  always_comb begin
    cmp_bad = (instr_i[31:27] != 5'b11110) ||
              (instr_i[25:24] != 2'b11) ||
              (instr_i[23:21] != 3'b011) ||
              instr_i[20] || instr_i[15];
    cmp_f.cond    = 4'hE;
    cmp_f.rn      = instr_i[19:16];
    cmp_f.rd      = instr_i[11:8];
    cmp_f.bot     = {instr_i[14:12], instr_i[7:6]};
    cmp_f.top     = instr_i[4:0];
    cmp_f.enc_bad = cmp_bad;
  end

  assign fields_o      = (fmt_i == FMT_COMPACT) ? cmp_f : wide_f;
  assign conditional_o = (fmt_i == FMT_WIDE);
endmodule

// File: rtl/bfx_cond.sv
module bfx_cond
  import bfx_pkg::*;
(
  input  logic       conditional_i,
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);
  assign pass_o = conditional_i ? cond_holds(cond_i, flags_i) : 1'b1;
endmodule

// File: rtl/bfx_merge.sv
module bfx_merge
  import bfx_pkg::*;
(
  input  logic [POS_W-1:0]  top_i,
  input  logic [POS_W-1:0]  bot_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] shifted;

  assign mask_o  = span_mask(top_i, bot_i);
  assign shifted = clear_i ? '0 : (src_i << bot_i);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign merged_o[b] = mask_o[b] ? shifted[b] : dst_i[b];
  end

  always_comb begin
    assert_keep_outside_R1: assert (((merged_o ^ dst_i) & ~mask_o) == '0);
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              fmt_sel_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic [DATA_W-1:0] dst_val_i,
  input  logic [3:0]        flags_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic              wr_en_o,
  output logic              undef_o
);
  fields_t           fld;
  logic              conditional;
  logic              cond_pass;
  logic              rd_illegal;
  logic              bounds_crossed;
  logic              is_clear;
  logic              undef_now;
  logic              write_now;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] merged;

  bfx_decode u_decode (
    .fmt_i         (fmt_sel_i),
    .instr_i       (instr_i),
    .fields_o      (fld),
    .conditional_o (conditional)
  );

  bfx_cond u_cond (
    .conditional_i (conditional),
    .cond_i        (fld.cond),
    .flags_i       (flags_i),
    .pass_o        (cond_pass)
  );

  assign is_clear = (fld.rn == IDX_SPECIAL);

  bfx_merge u_merge (
    .top_i    (fld.top),
    .bot_i    (fld.bot),
    .clear_i  (is_clear),
    .src_i    (src_val_i),
    .dst_i    (dst_val_i),
    .mask_o   (mask),
    .merged_o (merged)
  );

  assign rd_illegal     = (fld.rd == IDX_SPECIAL);
  assign bounds_crossed = (fld.top < fld.bot);
  assign undef_now      = fld.enc_bad | rd_illegal | bounds_crossed;
  assign write_now      = ~undef_now & cond_pass;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      wr_en_o     <= 1'b0;
      undef_o     <= 1'b0;
      result_o    <= '0;
      dst_idx_o   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      wr_en_o     <= in_valid_i & write_now;
      undef_o     <= in_valid_i & undef_now;
      if (in_valid_i) begin
        result_o  <= write_now ? merged : dst_val_i;
        dst_idx_o <= fld.rd;
      end
    end
  end

  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!wr_en_o && !undef_o));
  assert_no_write_rd15_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (dst_idx_o != IDX_SPECIAL));
  assert_crossed_undef_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && bounds_crossed) |=> (undef_o && !wr_en_o));
  assert_cond_fail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !cond_pass) |=> !wr_en_o);
  assert_hold_dest_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !write_now) |=> (result_o == $past(dst_val_i)));
endmodule

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        fmt;
  logic [31:0] instr;
  logic [31:0] src;
  logic [31:0] dst;
  logic [3:0]  flags;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  dst_idx;
  logic        wr_en;
  logic        undef;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bfx_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .fmt_sel_i(fmt),
    .instr_i(instr), .src_val_i(src), .dst_val_i(dst), .flags_i(flags),
    .out_valid_o(out_valid), .result_o(result), .dst_idx_o(dst_idx),
    .wr_en_o(wr_en), .undef_o(undef)
  );

  typedef struct packed {
    logic        wr;
    logic        ud;
    logic [3:0]  idx;
    logic [31:0] res;
  } exp_t;

  function automatic logic [31:0] mk_wide(input logic [3:0] c, input logic [4:0] top,
      input logic [3:0] rd, input logic [4:0] bot, input logic [3:0] rn);
    return {c, 7'b0111110, top, rd, bot, 3'b001, rn};
  endfunction

  function automatic logic [31:0] mk_cmp(input logic [3:0] rn, input logic [4:0] bot,
      input logic [3:0] rd, input logic [4:0] top, input logic r26, input logic r5);
    return {5'b11110, r26, 2'b11, 3'b011, 1'b0, rn, 1'b0, bot[4:2], rd, bot[1:0], r5, top};
  endfunction

  function automatic logic tb_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;        4'h1: return !z;
      4'h2: return cy;       4'h3: return !cy;
      4'h4: return n;        4'h5: return !n;
      4'h6: return v;        4'h7: return !v;
      4'h8: return cy && !z; 4'h9: return !cy || z;
      4'hA: return n == v;   4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic exp_t model(input logic f, input logic [31:0] ins,
      input logic [31:0] s, input logic [31:0] d, input logic [3:0] fl);
    exp_t e;
    int top, bot;
    logic [3:0] rd, rn;
    logic bad, pass;
    if (!f) begin
      top = int'(ins[20:16]); bot = int'(ins[11:7]);
      rd = ins[15:12]; rn = ins[3:0];
      bad = (ins[31:28] == 4'hF) || (ins[27:21] != 7'h3E) || (ins[6:4] != 3'd1);
      pass = tb_cond(ins[31:28], fl);
    end else begin
      top = int'(ins[4:0]); bot = int'({ins[14:12], ins[7:6]});
      rd = ins[11:8]; rn = ins[19:16];
      bad = (ins[31:27] != 5'h1E) || (ins[25:21] != 5'b11011) || ins[20] || ins[15];
      pass = 1'b1;
    end
    e.ud  = bad || (rd == 4'hF) || (top < bot);
    e.wr  = !e.ud && pass;
    e.idx = rd;
    e.res = d;
    if (e.wr)
      for (int i = bot; i <= top; i++)
        e.res[i] = (rn == 4'hF) ? 1'b0 : s[i - bot];
    return e;
  endfunction

  task automatic apply(input logic f, input logic [31:0] ins, input logic [31:0] s,
      input logic [31:0] d, input logic [3:0] fl, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; fmt = f; instr = ins; src = s; dst = d; flags = fl;
    e = model(f, ins, s, d, fl);
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || wr_en !== e.wr || undef !== e.ud || dst_idx !== e.idx || result !== e.res) begin
      errors++;
      $display("FAIL %s: got v=%0b wr=%0b ud=%0b idx=%0d res=%h, expected v=1 wr=%0b ud=%0b idx=%0d res=%h",
               tag, out_valid, wr_en, undef, dst_idx, result, e.wr, e.ud, e.idx, e.res);
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (out_valid || wr_en || undef) begin
      errors++;
      $display("FAIL %s: got v=%0b wr=%0b ud=%0b, expected 0 0 0", tag, out_valid, wr_en, undef);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; in_valid = 1'b0; fmt = 1'b0; instr = '0; src = '0; dst = '0; flags = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid || wr_en || undef || result != 0 || dst_idx != 0) begin
      errors++;
      $display("FAIL R13 reset: got v=%0b wr=%0b ud=%0b res=%h idx=%0d, expected all zero",
               out_valid, wr_en, undef, result, dst_idx);
    end
    rst_n = 1'b1;

    apply(0, mk_wide(4'hE, 5'd31, 4'd2, 5'd0, 4'd3), 32'hCAFEF00D, 32'h0, 4'h0, "R1 full width");
    apply(0, mk_wide(4'hE, 5'd31, 4'd2, 5'd31, 4'd3), 32'h1, 32'h0, 4'h0, "R1 top bit only");
    apply(0, mk_wide(4'hE, 5'd0, 4'd2, 5'd0, 4'd3), 32'h0, 32'hFFFFFFFF, 4'h0, "R1 bit zero only");
    apply(0, mk_wide(4'hE, 5'd15, 4'd7, 5'd8, 4'd1), 32'h12345678, 32'hA5A5A5A5, 4'h0, "R2 mid field");
    apply(1, mk_cmp(4'd4, 5'd13, 4'd6, 5'd20, 0, 0), 32'hFFFFFFFF, 32'h0, 4'h0, "R3 compact bounds");
    apply(0, mk_wide(4'hE, 5'd23, 4'd1, 5'd4, 4'hF), 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h0, "R4 clear wide");
    apply(1, mk_cmp(4'hF, 5'd0, 4'd1, 5'd31, 0, 0), 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h0, "R4 clear compact");
    apply(0, mk_wide(4'hE, 5'd9, 4'hF, 5'd2, 4'd0), 32'h3, 32'h77, 4'h0, "R5 rd 15 wide");
    apply(1, mk_cmp(4'd0, 5'd2, 4'hF, 5'd9, 0, 0), 32'h3, 32'h77, 4'h0, "R5 rd 15 compact");
    apply(0, mk_wide(4'hE, 5'd3, 4'd2, 5'd4, 4'd0), 32'hF, 32'h55, 4'h0, "R6 crossed bounds");
    apply(1, mk_cmp(4'd0, 5'd31, 4'd2, 5'd0, 0, 0), 32'hF, 32'h55, 4'h0, "R6 crossed compact");
    apply(0, mk_wide(4'hF, 5'd7, 4'd2, 5'd0, 4'd0), 32'hF, 32'h55, 4'h0, "R7 cond 1111");
    apply(0, mk_wide(4'hE, 5'd7, 4'd2, 5'd0, 4'd0) ^ 32'h0000_0010, 32'hF, 32'h55, 4'h0, "R7 opcode bit");
    apply(1, mk_cmp(4'd0, 5'd0, 4'd2, 5'd7, 0, 0) ^ 32'h0000_8000, 32'hF, 32'h55, 4'h0, "R7 compact bit15");
    apply(0, mk_wide(4'h0, 5'd7, 4'd2, 5'd0, 4'd0), 32'hF, 32'h55, 4'h0, "R8 EQ fails");
    apply(0, mk_wide(4'h0, 5'd7, 4'd2, 5'd0, 4'd0), 32'hF, 32'h55, 4'h4, "R8 EQ passes");
    apply(0, mk_wide(4'hC, 5'd7, 4'd2, 5'd0, 4'd0), 32'hF, 32'h55, 4'h9, "R8 GT with N==V");
    apply(1, mk_cmp(4'd1, 5'd4, 4'd3, 5'd11, 0, 0), 32'hABCD, 32'h0, 4'hF, "R9 compact flags F");
    apply(1, mk_cmp(4'd1, 5'd4, 4'd3, 5'd11, 0, 0), 32'hABCD, 32'h0, 4'h0, "R9 compact flags 0");
    apply(1, mk_cmp(4'd1, 5'd4, 4'd3, 5'd11, 1, 1), 32'hABCD, 32'h0, 4'h0, "R12 reserved bits set");
    apply(1, mk_cmp(4'd1, 5'd4, 4'd3, 5'd11, 1, 0), 32'hABCD, 32'h0, 4'h5, "R12 bit26 only");
    apply(0, mk_wide(4'h1, 5'd20, 4'd5, 5'd10, 4'd6), 32'h3FF, 32'hDEADBEEF, 4'h4, "R11 hold on fail");
    check_idle("R10 idle cycle");

    for (int k = 0; k < 600; k++) begin
      logic f;
      logic [4:0] a, b;
      logic [3:0] c, rd, rn;
      f  = 1'($urandom_range(0, 1));
      a  = ($urandom_range(0, 3) == 0) ? 5'(31 * $urandom_range(0, 1)) : 5'($urandom);
      b  = ($urandom_range(0, 3) == 0) ? 5'(31 * $urandom_range(0, 1)) : 5'($urandom_range(0, 31));
      if ($urandom_range(0, 4) != 0 && a < b) {a, b} = {b, a};
      c  = 4'($urandom);
      rd = ($urandom_range(0, 7) == 0) ? 4'hF : 4'($urandom);
      rn = ($urandom_range(0, 7) == 0) ? 4'hF : 4'($urandom);
      w  = f ? mk_cmp(rn, b, rd, a, 1'($urandom), 1'($urandom)) : mk_wide(c, a, rd, b, rn);
      if ($urandom_range(0, 7) == 0) w = w ^ (32'h1 << $urandom_range(0, 31));
      apply(f, w, $urandom, $urandom, 4'($urandom), "R1 R2 R3 R8 random");
      if ($urandom_range(0, 15) == 0) check_idle("R10 random idle");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule